// File: doc/BRIEF.md
# DSP Multiply-Accumulate Execution Unit

This block is the multiplier datapath of a 16-bit fixed-point DSP core. A decoded instruction word arrives with a valid strobe. The four halves of the two secondary accumulators arrive as plain inputs, and so does the multiply-modify mode bit of the status register. The unit forms a signed 16x16 product and doubles it unless the mode bit is set. The product then replaces the wide product register, or is added to it, or is subtracted from it.

The unit holds the two 40-bit main accumulators and the flag bits that depend on them. Several instruction forms also write the product register's previous value into one main accumulator, in the same cycle that the new product is stored. That previous value is either copied, added to the accumulator, or rounded first. These forms update the flags from the new accumulator value. Each accepted instruction completes in one clock and pulses a done strobe.

Top module: `mac_unit`

## Requirements
- R1: After reset is released, prod_o, acc0_o, acc1_o and flags_o are all zero and done_o is low.
- R2: Both operands are taken as signed 16-bit values. The 32-bit product is sign-extended to 40 bits and shifted left by one when unscaled_i is 0; it is left as is when unscaled_i is 1.
- R3: Overwrite forms load the new product into prod_o and leave the accumulators and flags unchanged. The top byte of instr_i is 1001 s000 for the low half of secondary accumulator s times its high half, and 110s t000 for the middle of main accumulator s times the high half of secondary accumulator t.
- R4: Accumulating forms add the new product to prod_o or subtract it from prod_o, wrapping at 40 bits. The top byte is 1111 0d1s for the low half of secondary accumulator s times its high half, and 1110 1dst for the middle of main accumulator s times the high half of secondary accumulator t. In both patterns d=0 adds and d=1 subtracts.
- R5: When bits 10:9 are 10 in the 1001 s10r and 110s t10r patterns, accumulator r receives its old value plus the old product, and prod_o receives the new product.
- R6: When bits 10:9 are 11, accumulator r receives the old product unchanged, and prod_o receives the new product.
- R7: When bits 10:9 are 01, accumulator r receives (old product + 0x8000) with bits 15:0 cleared, and prod_o receives the new product.
- R8: The operand selectors are decoded from fixed bits. In the 1001 group, s is bit 11. In the 110 group, s is bit 12 and t is bit 11. In the 1110 1 group, s is bit 9 and t is bit 8. In the 1111 0 group, s is bit 8. The accumulator middle is bits 31:16.
- R9: An instruction that writes an accumulator sets the flags from the new value: flags_o[0] when the value is zero, flags_o[1] to bit 39, flags_o[2] when bits 39:31 are not all equal, and flags_o[3] cleared. Other instructions leave the flags unchanged.
- R10: done_o goes high in the cycle after a clock edge at which valid_i is high with a recognised word. An unrecognised word, or valid_i low, changes no output and leaves done_o low.
- R11: One instruction writes at most one main accumulator, the one selected by bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Decoded instruction word |
| ax0_h_i | input | DATA_W | High half of secondary accumulator 0 |
| ax0_l_i | input | DATA_W | Low half of secondary accumulator 0 |
| ax1_h_i | input | DATA_W | High half of secondary accumulator 1 |
| ax1_l_i | input | DATA_W | Low half of secondary accumulator 1 |
| unscaled_i | input | 1 | Multiply-modify mode bit; 1 suppresses doubling |
| prod_o | output | ACC_W | Product register |
| acc0_o | output | ACC_W | Main accumulator 0 |
| acc1_o | output | ACC_W | Main accumulator 1 |
| flags_o | output | 4 | Zero, negative, beyond-32-bit, overflow (cleared) |
| done_o | output | 1 | Instruction completed |

## Verification
The bench builds the unit with the default DATA_W=16 and ACC_W=40, so the guard bits above bit 31 are exercised by real values. The largest doubled product, 0x8000 times 0x8000, lands exactly on bit 31. A run of 520 accumulating steps wraps the product register past bit 39. Moving that sum into an accumulator raises the beyond-32-bit flag. The rounding threshold at 0x8000 is tested from both sides with the multiply-modify bit set, so that exact low halves can be reached.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned NUM_ACC = 2;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned FLAG_Z  = 0;
  localparam int unsigned FLAG_N  = 1;
  localparam int unsigned FLAG_E  = 2;
  localparam int unsigned FLAG_V  = 3;

  typedef enum logic [1:0] {PROD_HOLD, PROD_LOAD, PROD_ADD, PROD_SUB} prod_op_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_ROUND, ACC_SUM, ACC_MOVE} acc_op_e;

  typedef struct packed {
    logic     legal;
    prod_op_e prod_op;
    acc_op_e  acc_op;
    logic     a_acc;   // operand a from accumulator middle
    logic     a_sel;
    logic     b_sel;
    logic     dst;
  } mac_cmd_t;

  // bits 10:9 of the multiply groups pick the accumulator side effect
  function automatic acc_op_e acc_op_of(input logic [1:0] f);
    case (f)
      2'b01:   return ACC_ROUND;
      2'b10:   return ACC_SUM;
      2'b11:   return ACC_MOVE;
      default: return ACC_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output mac_cmd_t           cmd_o
);
  always_comb begin
    cmd_o         = '0;
    cmd_o.prod_op = PROD_HOLD;
    cmd_o.acc_op  = ACC_HOLD;
    cmd_o.dst     = instr_i[8];
    casez (instr_i[15:8])
      8'b1001_?000, 8'b1001_?01?, 8'b1001_?1??: begin
        cmd_o.legal   = 1'b1;
        cmd_o.prod_op = PROD_LOAD;
        cmd_o.acc_op  = acc_op_of(instr_i[10:9]);
        cmd_o.a_sel   = instr_i[11];
        cmd_o.b_sel   = instr_i[11];
      end
      8'b110?_?000, 8'b110?_?01?, 8'b110?_?1??: begin
        cmd_o.legal   = 1'b1;
        cmd_o.prod_op = PROD_LOAD;
        cmd_o.acc_op  = acc_op_of(instr_i[10:9]);
        cmd_o.a_acc   = 1'b1;
        cmd_o.a_sel   = instr_i[12];
        cmd_o.b_sel   = instr_i[11];
      end
      8'b1110_1???: begin
        cmd_o.legal   = 1'b1;
        cmd_o.prod_op = instr_i[10] ? PROD_SUB : PROD_ADD;
        cmd_o.a_acc   = 1'b1;
        cmd_o.a_sel   = instr_i[9];
        cmd_o.b_sel   = instr_i[8];
      end
      8'b1111_0?1?: begin
        cmd_o.legal   = 1'b1;
        cmd_o.prod_op = instr_i[10] ? PROD_SUB : PROD_ADD;
        cmd_o.a_sel   = instr_i[8];
        cmd_o.b_sel   = instr_i[8];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              unscaled_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] raw;
  logic        [ACC_W-1:0]  ext;

  assign raw    = $signed(a_i) * $signed(b_i);
  assign ext    = {{(ACC_W-PROD_W){raw[PROD_W-1]}}, raw};
  assign prod_o = unscaled_i ? ext : (ext << 1);
endmodule

// File: rtl/mac_acc_path.sv
module mac_acc_path
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  prod_op_e          prod_op_i,
  input  acc_op_e           acc_op_i,
  input  logic [ACC_W-1:0]  prod_q_i,
  input  logic [ACC_W-1:0]  acc_old_i,
  input  logic [ACC_W-1:0]  mult_i,
  output logic [ACC_W-1:0]  prod_d_o,
  output logic [ACC_W-1:0]  acc_d_o,
  output logic [FLAG_W-1:0] flags_d_o
);
  localparam int unsigned     TOP_LSB = 2 * DATA_W - 1;
  localparam logic [ACC_W-1:0] ONE    = {{(ACC_W-1){1'b0}}, 1'b1};
  localparam logic [ACC_W-1:0] RND_INC  = ONE << (DATA_W - 1);
  localparam logic [ACC_W-1:0] RND_MASK = ~((ONE << DATA_W) - ONE);

  logic [ACC_W-1:TOP_LSB] top;

  always_comb begin
    case (prod_op_i)
      PROD_LOAD: prod_d_o = mult_i;
      PROD_ADD:  prod_d_o = prod_q_i + mult_i;
      PROD_SUB:  prod_d_o = prod_q_i - mult_i;
      default:   prod_d_o = prod_q_i;
    endcase
  end

  always_comb begin
    case (acc_op_i)
      ACC_SUM:   acc_d_o = acc_old_i + prod_q_i;
      ACC_MOVE:  acc_d_o = prod_q_i;
      ACC_ROUND: acc_d_o = (prod_q_i + RND_INC) & RND_MASK;
      default:   acc_d_o = acc_old_i;
    endcase
  end

  assign top = acc_d_o[ACC_W-1:TOP_LSB];

  always_comb begin
    flags_d_o         = '0;
    flags_d_o[FLAG_Z] = (acc_d_o == '0);
    flags_d_o[FLAG_N] = acc_d_o[ACC_W-1];
    flags_d_o[FLAG_E] = !((&top) || (~|top));
    flags_d_o[FLAG_V] = 1'b0;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [DATA_W-1:0]   ax0_h_i,
  input  logic [DATA_W-1:0]   ax0_l_i,
  input  logic [DATA_W-1:0]   ax1_h_i,
  input  logic [DATA_W-1:0]   ax1_l_i,
  input  logic                unscaled_i,
  output logic [ACC_W-1:0]    prod_o,
  output logic [ACC_W-1:0]    acc0_o,
  output logic [ACC_W-1:0]    acc1_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                done_o
);
  localparam int unsigned MID_LO = DATA_W;
  localparam int unsigned MID_HI = 2 * DATA_W - 1;

  logic [DATA_W-1:0] ax_h [NUM_ACC];
  logic [DATA_W-1:0] ax_l [NUM_ACC];
  logic [ACC_W-1:0]  acc_q [NUM_ACC];

  mac_cmd_t          cmd;
  logic              fire, acc_wr;
  logic [DATA_W-1:0] op_a, op_b;
  logic [ACC_W-1:0]  mult, prod_d, acc_d, acc_old;
  logic [ACC_W-1:0]  prod_q;
  logic [FLAG_W-1:0] flags_d, flags_q;
  logic              done_q;

  assign ax_h[0] = ax0_h_i;
  assign ax_h[1] = ax1_h_i;
  assign ax_l[0] = ax0_l_i;
  assign ax_l[1] = ax1_l_i;

  mac_decode u_dec (
    .instr_i (instr_i),
    .cmd_o   (cmd)
  );

  assign fire   = valid_i & cmd.legal;
  assign acc_wr = fire && (cmd.acc_op != ACC_HOLD);
  assign op_a   = cmd.a_acc ? acc_q[cmd.a_sel][MID_HI:MID_LO] : ax_l[cmd.a_sel];
  assign op_b   = ax_h[cmd.b_sel];
  assign acc_old = acc_q[cmd.dst];

  mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .a_i        (op_a),
    .b_i        (op_b),
    .unscaled_i (unscaled_i),
    .prod_o     (mult)
  );

  mac_acc_path #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_path (
    .prod_op_i (cmd.prod_op),
    .acc_op_i  (cmd.acc_op),
    .prod_q_i  (prod_q),
    .acc_old_i (acc_old),
    .mult_i    (mult),
    .prod_d_o  (prod_d),
    .acc_d_o   (acc_d),
    .flags_d_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire)   prod_q  <= prod_d;
      if (acc_wr) flags_q <= flags_d;
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (acc_wr && (cmd.dst == g))  q <= acc_d;
    end
    assign acc_q[g] = q;
  end

  assign prod_o  = prod_q;
  assign acc0_o  = acc_q[0];
  assign acc1_o  = acc_q[1];
  assign flags_o = flags_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [ACC_W-1:0] prod_o,
  input logic [ACC_W-1:0] acc0_o,
  input logic [ACC_W-1:0] acc1_o,
  input logic [3:0]       flags_o,
  input logic             done_o
);
  a_r10_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  a_r10_idle_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(prod_o) && $stable(acc0_o) && $stable(acc1_o) && $stable(flags_o)));

  a_r11_single_acc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(acc0_o) && !$stable(acc1_o)));

  a_r9_zero_flag_acc0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc0_o) |-> (flags_o[0] == (acc0_o == '0)));

  a_r9_neg_flag_acc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc1_o) |-> (flags_o[1] == acc1_o[ACC_W-1]));
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .prod_o  (prod_o),
  .acc0_o  (acc0_o),
  .acc1_o  (acc1_o),
  .flags_o (flags_o),
  .done_o  (done_o)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
  localparam int DW = 16;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [15:0]   instr_i = '0;
  logic [DW-1:0] ax0_h_i = '0, ax0_l_i = '0, ax1_h_i = '0, ax1_l_i = '0;
  logic          unscaled_i = 1'b0;
  logic [AW-1:0] prod_o, acc0_o, acc1_o;
  logic [3:0]    flags_o;
  logic          done_o;

  mac_unit #(.DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .ax0_h_i(ax0_h_i), .ax0_l_i(ax0_l_i), .ax1_h_i(ax1_h_i), .ax1_l_i(ax1_l_i),
    .unscaled_i(unscaled_i), .prod_o(prod_o), .acc0_o(acc0_o), .acc1_o(acc1_o),
    .flags_o(flags_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_prod;
  logic [AW-1:0] m_acc [2];
  logic [3:0]    m_flags;

  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] a0h, a0l, a1h, a1l;
    logic        uns;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{16'h9000, 16'h0003, 16'h0005, 16'h0000, 16'h0000, 1'b0},
    '{16'h9800, 16'h0000, 16'h0000, 16'hFFFE, 16'h0007, 1'b0},
    '{16'h9600, 16'h0010, 16'h0010, 16'h1234, 16'h8001, 1'b1},
    '{16'h9F00, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, 1'b0},
    '{16'h9400, 16'h0100, 16'hFF00, 16'h0002, 16'h0003, 1'b0},
    '{16'h9D00, 16'h0001, 16'h0001, 16'h4000, 16'hC000, 1'b1},
    '{16'h9200, 16'h00FF, 16'h0101, 16'h0000, 16'h0000, 1'b0},
    '{16'h9B00, 16'h0000, 16'h0000, 16'hABCD, 16'h1234, 1'b0},
    '{16'hC000, 16'h0005, 16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    '{16'hD800, 16'h0000, 16'h0000, 16'h0300, 16'h0000, 1'b1},
    '{16'hC600, 16'h8000, 16'h0000, 16'h0001, 16'h0000, 1'b0},
    '{16'hDD00, 16'h0000, 16'h0000, 16'h7FFF, 16'h0000, 1'b0},
    '{16'hC400, 16'h0020, 16'h0000, 16'h0040, 16'h0000, 1'b1},
    '{16'hCA00, 16'h1111, 16'h0000, 16'h2222, 16'h0000, 1'b0},
    '{16'hE800, 16'h0007, 16'h0000, 16'h0009, 16'h0000, 1'b0},
    '{16'hED00, 16'h0000, 16'h0000, 16'hF000, 16'h0000, 1'b1},
    '{16'hEB00, 16'h0000, 16'h0000, 16'h0055, 16'h0000, 1'b0},
    '{16'hF200, 16'hFFFD, 16'h0004, 16'h0000, 16'h0000, 1'b0},
    '{16'hF300, 16'h0000, 16'h0000, 16'h0011, 16'hFFEF, 1'b1},
    '{16'hF600, 16'h0100, 16'h0100, 16'h0000, 16'h0000, 1'b0},
    '{16'h9100, 16'h1234, 16'h5678, 16'h0001, 16'h0001, 1'b0},
    '{16'h0000, 16'h1234, 16'h5678, 16'h0001, 16'h0001, 1'b0}
  };

  task automatic chk(input string tag, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] mval(input logic [15:0] a, input logic [15:0] b, input logic uns);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    if (!uns) p = p * 2;
    return p[AW-1:0];
  endfunction

  task automatic wr_acc(input logic r, input logic [AW-1:0] v);
    m_acc[r] = v;
    m_flags  = {1'b0, !((&v[39:31]) || (~|v[39:31])), v[39], (v == '0)};
  endtask

  task automatic acc_side(input logic [1:0] f, input logic r, input logic [AW-1:0] old, output string tag);
    case (f)
      2'b01:   begin wr_acc(r, (old + 40'h8000) & ~40'hFFFF); tag = "R7"; end
      2'b10:   begin wr_acc(r, m_acc[r] + old); tag = "R5"; end
      2'b11:   begin wr_acc(r, old); tag = "R6"; end
      default: tag = "R3";
    endcase
  endtask

  task automatic predict(input logic [15:0] ins, input logic uns, output bit legal, output string tag);
    logic [15:0]   xh [2];
    logic [15:0]   xl [2];
    logic [AW-1:0] old, mv;
    xh[0] = ax0_h_i; xh[1] = ax1_h_i;
    xl[0] = ax0_l_i; xl[1] = ax1_l_i;
    old = m_prod;
    legal = 1'b1;
    tag = "R10";
    casez (ins[15:8])
      8'b1001_?000, 8'b1001_?01?, 8'b1001_?1??: begin
        m_prod = mval(xl[ins[11]], xh[ins[11]], uns);
        acc_side(ins[10:9], ins[8], old, tag);
      end
      8'b110?_?000, 8'b110?_?01?, 8'b110?_?1??: begin
        m_prod = mval(m_acc[ins[12]][31:16], xh[ins[11]], uns);
        acc_side(ins[10:9], ins[8], old, tag);
      end
      8'b1110_1???: begin
        mv = mval(m_acc[ins[9]][31:16], xh[ins[8]], uns);
        m_prod = ins[10] ? old - mv : old + mv;
        tag = "R4";
      end
      8'b1111_0?1?: begin
        mv = mval(xl[ins[8]], xh[ins[8]], uns);
        m_prod = ins[10] ? old - mv : old + mv;
        tag = "R4";
      end
      default: legal = 1'b0;
    endcase
  endtask

  task automatic step(input logic [15:0] ins, input logic [15:0] a0h, input logic [15:0] a0l,
                      input logic [15:0] a1h, input logic [15:0] a1l, input logic uns, input logic v);
    bit    legal;
    string tag;
    instr_i = ins; ax0_h_i = a0h; ax0_l_i = a0l; ax1_h_i = a1h; ax1_l_i = a1l;
    unscaled_i = uns; valid_i = v;
    legal = 1'b0;
    tag = "R10";
    if (v) predict(ins, uns, legal, tag);
    @(negedge clk);
    valid_i = 1'b0;
    chk(tag, "prod", prod_o, m_prod);
    chk(tag, "acc0", acc0_o, m_acc[0]);
    chk(tag, "acc1", acc1_o, m_acc[1]);
    chk("R9", "flags", {36'd0, flags_o}, {36'd0, m_flags});
    chk("R10", "done", {39'd0, done_o}, {39'd0, legal});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: got hang expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] nib [5];
    nib[0] = 4'h9; nib[1] = 4'hC; nib[2] = 4'hD; nib[3] = 4'hE; nib[4] = 4'hF;
    m_prod = '0; m_acc[0] = '0; m_acc[1] = '0; m_flags = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "prod", prod_o, '0);
    chk("R1", "acc0", acc0_o, '0);
    chk("R1", "acc1", acc1_o, '0);
    chk("R1", "flags", {36'd0, flags_o}, '0);
    chk("R1", "done", {39'd0, done_o}, '0);

    // R10 legal word with valid low has no effect
    step(16'h9000, 16'h0003, 16'h0003, 16'h0, 16'h0, 1'b0, 1'b0);
    chk("R10", "prod idle", prod_o, '0);

    // R2 full-scale doubling and the unscaled setting
    step(16'h9000, 16'h8000, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b1);
    chk("R2", "prod doubled", prod_o, 40'h0080000000);
    step(16'h9000, 16'h8000, 16'h8000, 16'h0, 16'h0, 1'b1, 1'b1);
    chk("R2", "prod unscaled", prod_o, 40'h0040000000);

    // R8 selector bit 11 picks secondary accumulator 1
    step(16'h9800, 16'h0000, 16'h0000, 16'h0003, 16'hFFFB, 1'b1, 1'b1);
    chk("R8", "prod ax1", prod_o, 40'hFFFFFFFFF1);

    // R7 rounding threshold from both sides
    step(16'h9000, 16'h4000, 16'h0002, 16'h0, 16'h0, 1'b1, 1'b1);
    step(16'h9200, 16'h7FFF, 16'h0001, 16'h0, 16'h0, 1'b1, 1'b1);
    chk("R7", "acc0 round up", acc0_o, 40'h0000010000);
    chk("R7", "prod new", prod_o, 40'h0000007FFF);
    step(16'h9300, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1);
    chk("R7", "acc1 round down", acc1_o, 40'h0);
    chk("R9", "zero flag", {36'd0, flags_o}, 40'h1);

    // R9 negative value, R11 other accumulator untouched
    step(16'h9000, 16'h0002, 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b1);
    step(16'h9700, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1);
    chk("R6", "acc1 move", acc1_o, 40'hFFFFFFFFFC);
    chk("R9", "neg flag", {36'd0, flags_o}, 40'h2);
    chk("R11", "acc0 kept", acc0_o, 40'h0000010000);

    // R4 40-bit wrap over 520 full-scale accumulations
    step(16'h9000, 16'h8000, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b1);
    for (int i = 0; i < 519; i++) step(16'hF200, 16'h8000, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b1);
    chk("R4", "prod wrapped", prod_o, 40'h0400000000);
    step(16'h9600, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1);
    chk("R9", "ext flag", {36'd0, flags_o}, 40'h4);

    // table of vectors
    for (int i = 0; i < NV; i++)
      step(VECS[i].ins, VECS[i].a0h, VECS[i].a0l, VECS[i].a1h, VECS[i].a1l, VECS[i].uns, 1'b1);

    // random mix, legal and illegal words across the multiply groups
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      w[15:12] = nib[$urandom % 5];
      step(w, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom % 8 != 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule